// File: doc/BRIEF.md
# Multiplexed Asynchronous Bus Target

This block is the responding side of an asynchronous bus on which address and data share one set of lines. The initiator asserts a cycle-framing line while the address is on the shared lines. The target captures all 22 address bits and compares them against a window set by parameters. When the address falls inside the window, the target answers the read and write strobes that follow on the same lines. Each strobe is answered with a reply, and the reply is held until the initiator withdraws that strobe. There is no bus clock. The target samples every bus control through two-flop synchronizers into its own clock domain.

The storage behind the window is a small word array with byte lanes. A single addressed cycle can carry a word read, a word write, a byte write, or a read followed by one write to the same address (read-modify-write). The shared lines are modelled as separate input, output and output-enable vectors, so that an open-drain or wired-OR driver can be placed outside the block. The target does not support block transfers, and its block-capability output stays low.

Top module: `mabus_target`

## Requirements
- R1: After reset, `reply_o`, `bus_ad_oe` and `blk_cap_o` are all low.
- R2: The address is taken from all 22 bits of `bus_ad_i` when `frame_i` is asserted. The target answers only when BASE_ADDR <= address < BASE_ADDR + 2*WIN_WORDS. An address that differs from a window address only in bits 21:18, or that lies just past the window, gets no reply to any strobe.
- R3: In a matched cycle that is not marked as a write, a read strobe (`rd_strobe_i`) is answered with `reply_o`. While the reply is up, the stored word addressed by (address - BASE_ADDR) >> 1 is driven on `bus_ad_o` with `bus_ad_oe` high.
- R4: `reply_o` stays high until the strobe it answers is seen low. After that, the reply and `bus_ad_oe` drop in the clock after the synchronized strobe goes low.
- R5: A write strobe (`wr_strobe_i`) with `wtq_i` low stores all 16 bits of `bus_ad_i[15:0]` into the addressed word and is answered with `reply_o`.
- R6: A write strobe with `wtq_i` high is a byte write. If address bit 0 is 0, only bits 7:0 are stored, taken from `bus_ad_i[7:0]`. If address bit 0 is 1, only bits 15:8 are stored, taken from `bus_ad_i[15:8]`. The other byte keeps its value.
- R7: In a matched cycle that is not marked as a write, after the read handshake completes, one write strobe is accepted to the same latched address without a new address phase.
- R8: If `wtq_i` is high when the address is latched, the cycle is a write cycle. Read strobes in it get no reply, and `bus_ad_oe` stays low.
- R9: At most one write is accepted per cycle. Further strobes in that cycle are not answered and do not change storage.
- R10: `blk_cap_o` is never asserted.
- R11: Bus controls pass through two-flop synchronizers. A reply never rises unless a strobe was high at the port three clock edges earlier.
- R12: When `frame_i` is withdrawn, the target ends the cycle. `reply_o` and `bus_ad_oe` are low by the clock after the synchronized frame goes low, even if a strobe is still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_ad_i | input | 22 | Received shared address/data lines (data on bits 15:0) |
| bus_ad_o | output | 16 | Read data to drive onto the shared lines |
| bus_ad_oe | output | 1 | Drive enable for `bus_ad_o` |
| frame_i | input | 1 | Cycle framing; the address is latched when it is asserted |
| rd_strobe_i | input | 1 | Data-in (read) strobe |
| wr_strobe_i | input | 1 | Data-out (write) strobe |
| wtq_i | input | 1 | Write mark during the address phase, byte qualifier during the data phase |
| reply_o | output | 1 | Reply handshake to the initiator |
| blk_cap_o | output | 1 | Block-transfer capability indication, held low |

## Verification
The bench probes an alias address that matches a window address in its low 18 bits. A target that decoded only 18 bits would answer there and overwrite the real word. The bench also places accesses on the last word of the window and on the first byte past it, where an off-by-one in the range compare would add or lose a reply. Byte writes to both lanes, followed by word reads, expose a lane swap or a write that spills into the neighbouring byte. Read-modify-write, a second write in one cycle, and a read in a write-marked cycle show whether the per-cycle bookkeeping answers strobes it should refuse. Withdrawing the frame in the middle of a read shows whether the target keeps driving the lines after the cycle has ended.

// File: rtl/mabus_pkg.sv
package mabus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_SEL,
        ST_RD,
        ST_WR,
        ST_SKIP
    } tgt_state_e;

    // byte-enable mask for a data phase: whole word, or one lane picked by the low address bits
    function automatic logic [1:0] lane_mask(input logic byte_op, input logic lane);
        if (!byte_op)  return 2'b11;
        else if (lane) return 2'b10;
        else           return 2'b01;
    endfunction

endpackage

// File: rtl/mabus_sync.sv
module mabus_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/mabus_win_decode.sv
module mabus_win_decode #(
    parameter int              ADDR_W    = 22,
    parameter logic [21:0]     BASE_ADDR = 22'h3FFF00,
    parameter int              WIN_WORDS = 8,
    parameter int              LANE_W    = 1
) (
    input  logic [ADDR_W-1:0]            addr_i,
    output logic                         hit_o,
    output logic [$clog2(WIN_WORDS)-1:0] idx_o
);
    localparam int IDX_W    = $clog2(WIN_WORDS);
    localparam int SPAN     = WIN_WORDS << LANE_W;

    logic [ADDR_W-1:0] off;

    always_comb begin
        off   = addr_i - ADDR_W'(BASE_ADDR);
        hit_o = (addr_i >= ADDR_W'(BASE_ADDR)) && (off < ADDR_W'(SPAN));
        idx_o = off[IDX_W+LANE_W-1:LANE_W];
    end
endmodule

// File: rtl/mabus_store.sv
module mabus_store #(
    parameter int DATA_W    = 16,
    parameter int WIN_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [DATA_W/8-1:0]          be_i,
    input  logic [$clog2(WIN_WORDS)-1:0] idx_i,
    input  logic [DATA_W-1:0]            wdata_i,
    output logic [DATA_W-1:0]            rdata_o
);
    localparam int BYTES = DATA_W / 8;

    logic [WIN_WORDS-1:0][DATA_W-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int w = 0; w < WIN_WORDS; w++) begin
            for (int b = 0; b < BYTES; b++) begin
                if (we_i && be_i[b] && (int'(idx_i) == w))
                    mem_d[w][b*8 +: 8] = wdata_i[b*8 +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/mabus_target.sv
module mabus_target
    import mabus_pkg::*;
#(
    parameter int          ADDR_W    = 22,
    parameter int          DATA_W    = 16,
    parameter logic [21:0] BASE_ADDR = 22'h3FFF00,
    parameter int          WIN_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_ad_i,
    output logic [DATA_W-1:0] bus_ad_o,
    output logic              bus_ad_oe,
    input  logic              frame_i,
    input  logic              rd_strobe_i,
    input  logic              wr_strobe_i,
    input  logic              wtq_i,
    output logic              reply_o,
    output logic              blk_cap_o
);
    localparam int BYTES  = DATA_W / 8;
    localparam int LANE_W = $clog2(BYTES);
    localparam int IDX_W  = $clog2(WIN_WORDS);

    typedef struct packed {
        tgt_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic              wmark;
        logic              rd_done;
        logic              wr_done;
        logic              reply;
        logic              oe;
        logic [DATA_W-1:0] dout;
    } tgt_reg_t;

    tgt_reg_t r_q, r_d;

    // synchronized controls
    logic [3:0] ctl_s;
    logic frame_s, rd_s, wr_s, wtq_s;

    mabus_sync #(.W(4)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({frame_i, rd_strobe_i, wr_strobe_i, wtq_i}),
        .sync_o  (ctl_s)
    );
    assign {frame_s, rd_s, wr_s, wtq_s} = ctl_s;

    logic             win_hit;
    logic [IDX_W-1:0] win_idx;

    mabus_win_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .WIN_WORDS (WIN_WORDS),
        .LANE_W    (LANE_W)
    ) u_dec (
        .addr_i (r_q.addr),
        .hit_o  (win_hit),
        .idx_o  (win_idx)
    );

    logic              st_we;
    logic [BYTES-1:0]  st_be;
    logic [DATA_W-1:0] st_rdata;

    mabus_store #(
        .DATA_W    (DATA_W),
        .WIN_WORDS (WIN_WORDS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (st_we),
        .be_i    (st_be),
        .idx_i   (win_idx),
        .wdata_i (bus_ad_i[DATA_W-1:0]),
        .rdata_o (st_rdata)
    );

    always_comb begin
        r_d   = r_q;
        st_we = 1'b0;
        st_be = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (frame_s) begin
                    r_d.addr    = bus_ad_i;
                    r_d.wmark   = wtq_s;
                    r_d.rd_done = 1'b0;
                    r_d.wr_done = 1'b0;
                    r_d.st      = ST_DECODE;
                end
            end
            ST_DECODE: begin
                r_d.st = win_hit ? ST_SEL : ST_SKIP;
            end
            ST_SEL: begin
                if (rd_s && !r_q.wmark && !r_q.rd_done && !r_q.wr_done) begin
                    r_d.dout    = st_rdata;
                    r_d.oe      = 1'b1;
                    r_d.reply   = 1'b1;
                    r_d.rd_done = 1'b1;
                    r_d.st      = ST_RD;
                end else if (wr_s && !r_q.wr_done) begin
                    st_we       = 1'b1;
                    st_be       = BYTES'(lane_mask(wtq_s, r_q.addr[0]));
                    r_d.reply   = 1'b1;
                    r_d.wr_done = 1'b1;
                    r_d.st      = ST_WR;
                end
            end
            ST_RD: begin
                if (!rd_s) begin
                    r_d.reply = 1'b0;
                    r_d.oe    = 1'b0;
                    r_d.st    = ST_SEL;
                end
            end
            ST_WR: begin
                if (!wr_s) begin
                    r_d.reply = 1'b0;
                    r_d.st    = ST_SEL;
                end
            end
            ST_SKIP: begin
                r_d.st = ST_SKIP;
            end
            default: r_d.st = ST_IDLE;
        endcase
        // frame withdrawn: abandon whatever is in flight
        if (!frame_s) begin
            r_d.st    = ST_IDLE;
            r_d.reply = 1'b0;
            r_d.oe    = 1'b0;
            st_we     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_ad_o  = r_q.dout;
    assign bus_ad_oe = r_q.oe;
    assign reply_o   = r_q.reply;
    assign blk_cap_o = 1'b0;
endmodule

// File: rtl/mabus_target_chk.sv
module mabus_target_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_strobe_i,
    input logic wr_strobe_i,
    input logic reply_o,
    input logic bus_ad_oe,
    input logic frame_s,
    input logic rd_s,
    input logic wr_s,
    input logic win_hit
);
    assert_oe_under_reply_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ad_oe |-> reply_o);

    assert_reply_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reply_o && frame_s && ((bus_ad_oe && rd_s) || (!bus_ad_oe && wr_s))) |=> reply_o);

    assert_drive_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ad_oe && !rd_s) |=> !bus_ad_oe);

    assert_reply_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reply_o) |-> win_hit);

    assert_reply_after_sync_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reply_o) |-> ($past(rd_strobe_i, 3) || $past(wr_strobe_i, 3)));

    assert_frame_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_s |=> (!reply_o && !bus_ad_oe));
endmodule

bind mabus_target mabus_target_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_strobe_i (rd_strobe_i),
    .wr_strobe_i (wr_strobe_i),
    .reply_o     (reply_o),
    .bus_ad_oe   (bus_ad_oe),
    .frame_s     (frame_s),
    .rd_s        (rd_s),
    .wr_s        (wr_s),
    .win_hit     (win_hit)
);

// File: tb/tb_mabus_target.sv
module tb_mabus_target;
    localparam logic [21:0] BASE = 22'h3FFF00;
    localparam int          WORDS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] bus_ad_i = '0;
    logic [15:0] bus_ad_o;
    logic        bus_ad_oe;
    logic        frame_i = 1'b0, rd_strobe_i = 1'b0, wr_strobe_i = 1'b0, wtq_i = 1'b0;
    logic        reply_o, blk_cap_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [15:0] exp_q[$];
    logic [15:0] model [WORDS];

    always #5 clk = ~clk;

    mabus_target #(.BASE_ADDR(BASE), .WIN_WORDS(WORDS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_ad_i(bus_ad_i), .bus_ad_o(bus_ad_o),
        .bus_ad_oe(bus_ad_oe), .frame_i(frame_i), .rd_strobe_i(rd_strobe_i),
        .wr_strobe_i(wr_strobe_i), .wtq_i(wtq_i), .reply_o(reply_o), .blk_cap_o(blk_cap_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard when the target drives read data
    bit seen = 0;
    always @(negedge clk) begin
        if (reply_o && bus_ad_oe && !seen) begin
            seen = 1;
            if (exp_q.size() == 0) check("R3 unexpected read data", 32'(bus_ad_o), 32'hFFFF_FFFF);
            else check("R3 read data", 32'(bus_ad_o), 32'(exp_q.pop_front()));
        end
        if (!reply_o) seen = 0;
    end

    task automatic wait_reply(input logic lvl, input string req);
        int n = 0;
        while (reply_o !== lvl && n < 12) begin @(negedge clk); n++; end
        check(req, 32'(reply_o), 32'(lvl));
    endtask

    task automatic start_cycle(input logic [21:0] a, input logic wmark);
        @(negedge clk);
        bus_ad_i = a; wtq_i = wmark; frame_i = 1'b1;
        repeat (4) @(negedge clk);
        wtq_i = 1'b0;
    endtask

    task automatic end_cycle();
        frame_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input logic [15:0] exp);
        exp_q.push_back(exp);
        rd_strobe_i = 1'b1;
        @(negedge clk);
        check("R11 no reply one clock after strobe", 32'(reply_o), 0);
        wait_reply(1'b1, "R3 read reply");
        repeat (3) @(negedge clk);
        check("R4 reply held while strobe high", 32'(reply_o), 1);
        rd_strobe_i = 1'b0;
        wait_reply(1'b0, "R4 reply released");
        check("R4 drive released", 32'(bus_ad_oe), 0);
    endtask

    task automatic do_write(input logic [15:0] d, input logic byte_op, input string req);
        bus_ad_i = {6'h0, d}; wtq_i = byte_op;
        @(negedge clk);
        wr_strobe_i = 1'b1;
        wait_reply(1'b1, req);
        wr_strobe_i = 1'b0;
        wait_reply(1'b0, "R4 write reply released");
        wtq_i = 1'b0;
    endtask

    task automatic no_reply_strobe(input bit is_rd, input string req);
        if (is_rd) rd_strobe_i = 1'b1; else wr_strobe_i = 1'b1;
        repeat (10) @(negedge clk);
        check(req, 32'(reply_o), 0);
        check(req, 32'(bus_ad_oe), 0);
        rd_strobe_i = 1'b0; wr_strobe_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic word_write(input logic [21:0] a, input logic [15:0] d);
        start_cycle(a, 1'b1);
        do_write(d, 1'b0, "R5 word write reply");
        end_cycle();
        model[(a - BASE) >> 1] = d;
    endtask

    task automatic word_read(input logic [21:0] a);
        start_cycle(a, 1'b0);
        do_read(model[(a - BASE) >> 1]);
        end_cycle();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < WORDS; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reply at reset", 32'(reply_o), 0);
        check("R1 oe at reset", 32'(bus_ad_oe), 0);
        check("R10 block capability at reset", 32'(blk_cap_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R5 / R3: word write then read, first and last words of the window (R2 boundary)
        word_write(BASE, 16'hA5C3);
        word_read(BASE);
        word_write(BASE + 22'hE, 16'h1234);
        word_read(BASE + 22'hE);

        // R6: byte lanes
        word_write(BASE + 22'h2, 16'hFFFF);
        start_cycle(BASE + 22'h2, 1'b1);
        do_write(16'h00AB, 1'b1, "R6 low byte write reply");
        end_cycle();
        model[1][7:0] = 8'hAB;
        start_cycle(BASE + 22'h3, 1'b1);
        do_write(16'h5500, 1'b1, "R6 high byte write reply");
        end_cycle();
        model[1][15:8] = 8'h55;
        word_read(BASE + 22'h2);
        check("R6 model word", 32'(model[1]), 32'h55AB);

        // R7: read-modify-write in one cycle
        start_cycle(BASE + 22'h4, 1'b0);
        do_read(16'h0000);
        do_write(16'h7777, 1'b0, "R7 write after read reply");
        end_cycle();
        model[2] = 16'h7777;
        word_read(BASE + 22'h4);

        // R8: read strobe in a write-marked cycle
        start_cycle(BASE, 1'b1);
        no_reply_strobe(1'b1, "R8 read in write cycle");
        end_cycle();

        // R9: second write in one cycle is refused
        start_cycle(BASE + 22'h6, 1'b1);
        do_write(16'h0F0F, 1'b0, "R9 first write reply");
        bus_ad_i = 22'h00BEEF;
        @(negedge clk);
        no_reply_strobe(1'b0, "R9 second write ignored");
        end_cycle();
        model[3] = 16'h0F0F;
        word_read(BASE + 22'h6);

        // R2: alias in upper bits and one past the window
        start_cycle(22'h03FF00, 1'b1);
        bus_ad_i = 22'h009999;
        no_reply_strobe(1'b0, "R2 alias write ignored");
        end_cycle();
        start_cycle(22'h03FF00, 1'b0);
        no_reply_strobe(1'b1, "R2 alias read ignored");
        end_cycle();
        start_cycle(BASE + 22'h10, 1'b0);
        no_reply_strobe(1'b1, "R2 past window ignored");
        end_cycle();
        word_read(BASE);

        // R12: frame withdrawn during a read
        start_cycle(BASE + 22'hE, 1'b0);
        exp_q.push_back(model[7]);
        rd_strobe_i = 1'b1;
        wait_reply(1'b1, "R12 read reply before abort");
        frame_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R12 reply after frame drop", 32'(reply_o), 0);
        check("R12 oe after frame drop", 32'(bus_ad_oe), 0);
        rd_strobe_i = 1'b0;
        repeat (4) @(negedge clk);

        check("R10 block capability at end", 32'(blk_cap_o), 0);
        check("R3 scoreboard drained", 32'(exp_q.size()), 0);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule